// File: doc/BRIEF.md
# Coherent Private-Cache Line Controller

This block tracks the coherence state of every line in a small private first-level cache that sits between a processor and a private next-level cache. For each line it keeps a state code and a dirty flag. It reacts to two event streams. The processor side delivers loads, instruction fetches, stores and replacements. The next-level side delivers fills, invalidates and forwarded requests. From these events it produces outgoing coherence messages, completion notices for the processor and eviction notices. Tags, data arrays, the network and the next-level cache all live outside the block.

A line is always in one of eight conditions. Five are stable: not present, invalid, shared, exclusive and modified. Three are waiting: a read miss waiting for data, a write miss waiting for data, and a shared line waiting for write permission. Processor events aimed at a waiting line are held back through the ready signal and go through once the line settles. Incoming messages are never held back. When a message and a processor event are both valid in the same cycle, the message takes the cycle. Each cycle the block handles at most one event, and that event emits at most one outgoing message.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is not present, all output valids are low and `cpu_ready` is high while `msg_valid` is low.
- R2: A load (`cpu_op`=0) or instruction fetch (1) to a not-present or invalid line issues GETS (`out_class`=0) and enters the read-wait state. A store (2) issues GETX (1) and enters the write-wait state. A replacement (3) of such a line emits nothing.
- R3: A processor event whose line is in a waiting state sees `cpu_ready` low and has no effect. Events to other lines are still accepted.
- R4: A store to a shared line issues UPGRADE (2) and enters the upgrade-wait state. A store to an exclusive or modified line completes at once with `hit_store`=1, marks the line dirty and leaves it modified.
- R5: A load or instruction fetch to a shared, exclusive or modified line completes at once with `hit_store`=0 and changes nothing.
- R6: Fill message classes are plain data (0), exclusive data (1) and stale data (2). In read-wait, plain data gives shared, exclusive data gives exclusive, and stale data completes the load but leaves the line invalid. In write-wait or upgrade-wait, exclusive data completes the store (`hit_store`=1) and leaves the line modified and dirty.
- R7: An invalidate (class 3) always answers INV_ACK (5). In not-present, invalid, read-wait and write-wait the state is unchanged. Upgrade-wait falls back to write-wait. Shared and exclusive lines are evicted to invalid. A modified line instead answers INV_DATA (4) with `out_has_data`=1 and its dirty flag, and is evicted to invalid.
- R8: A forwarded GETX (5), or an incoming UPGRADE-class message (7), acts like an invalidate on an exclusive or modified line and has no effect in any other state.
- R9: A forwarded GETS (4) or instruction-read request (6) to an exclusive or modified line sends INV_DATA carrying the dirty flag and leaves the line shared.
- R10: Replacing an exclusive or modified line sends PUTX (3) with the dirty flag, sets `out_has_data` equal to that flag, evicts the line and leaves it invalid. Replacing a shared line evicts it with no message.
- R11: An outgoing message appears on `out_*` exactly OUT_LAT (2) cycles after the cycle in which its event was accepted. Completion and eviction notices appear one cycle after that cycle.
- R12: While `msg_valid` is high, `cpu_ready` is low.
- R13: A write-back acknowledge (8), and any message with no defined action in the line's current state, produces no output and leaves the line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor event present |
| cpu_op | input | 2 | 0 load, 1 fetch, 2 store, 3 replacement |
| cpu_line | input | LW | Line index of processor event |
| cpu_ready | output | 1 | Processor event accepted this cycle |
| msg_valid | input | 1 | Incoming coherence message present |
| msg_class | input | 4 | Incoming message class (see R6 to R13) |
| msg_line | input | LW | Line index of incoming message |
| msg_dirty | input | 1 | Dirty flag carried by a fill |
| out_valid | output | 1 | Outgoing message valid |
| out_class | output | 3 | 0 GETS, 1 GETX, 2 UPGRADE, 3 PUTX, 4 INV_DATA, 5 INV_ACK |
| out_line | output | LW | Line index of outgoing message |
| out_dirty | output | 1 | Dirty flag carried by outgoing message |
| out_has_data | output | 1 | Outgoing message is sized as a data message |
| hit_valid | output | 1 | Processor access completed |
| hit_line | output | LW | Line of completed access |
| hit_store | output | 1 | Completed access was a store |
| evict_valid | output | 1 | Line removed from the processor's view |
| evict_line | output | LW | Evicted line index |

## Verification
A wrong state code shows up at the ports on the next event that touches the line. Examples are a GETS where a hit was due, a missing eviction, or an ack where INV_DATA was expected. That happens one or two cycles after that event is accepted. A wrong dirty flag stays hidden until the line leaves through a replacement or a modified-state invalidate, where `out_dirty` and `out_has_data` expose it. For this reason the stimulus routes lines through stores followed by write-backs. A waiting line that is stuck or released too early shows at once as a wrong `cpu_ready` level for the next processor event to that line.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [2:0] {
    ST_NP = 3'd0, ST_I = 3'd1, ST_S = 3'd2, ST_E = 3'd3,
    ST_M  = 3'd4, ST_IS = 3'd5, ST_IM = 3'd6, ST_SM = 3'd7
  } line_st_t;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0, OP_FETCH = 2'd1, OP_STORE = 2'd2, OP_REPL = 2'd3
  } cpu_op_t;

  typedef enum logic [3:0] {
    MC_DATA = 4'd0, MC_DATA_EX = 4'd1, MC_STALE = 4'd2, MC_INV = 4'd3,
    MC_FGETS = 4'd4, MC_FGETX = 4'd5, MC_FGETI = 4'd6, MC_UPGR = 4'd7,
    MC_WBACK = 4'd8
  } msg_cls_t;

  typedef enum logic [2:0] {
    OC_GETS = 3'd0, OC_GETX = 3'd1, OC_UPGR = 3'd2, OC_PUTX = 3'd3,
    OC_IDATA = 3'd4, OC_IACK = 3'd5
  } out_cls_t;

  function automatic logic is_wait(line_st_t s);
    return (s == ST_IS) || (s == ST_IM) || (s == ST_SM);
  endfunction
endpackage

// File: rtl/mesi_xfer.sv
module mesi_xfer
  import mesi_pkg::*;
(
  input  logic     ev_valid,
  input  logic     ev_msg,
  input  cpu_op_t  op,
  input  msg_cls_t mcls,
  input  logic     mdirty,
  input  line_st_t cur_st,
  input  logic     cur_dirty,
  output line_st_t nxt_st,
  output logic     nxt_dirty,
  output logic     send,
  output out_cls_t send_cls,
  output logic     send_dirty,
  output logic     send_data,
  output logic     hit,
  output logic     hit_st,
  output logic     evict
);
  always_comb begin
    nxt_st     = cur_st;
    nxt_dirty  = cur_dirty;
    send       = 1'b0;
    send_cls   = OC_GETS;
    send_dirty = 1'b0;
    send_data  = 1'b0;
    hit        = 1'b0;
    hit_st     = 1'b0;
    evict      = 1'b0;
    if (ev_valid && ev_msg) begin
      case (mcls)
        MC_DATA: if (cur_st == ST_IS) begin
          nxt_st = ST_S; nxt_dirty = mdirty; hit = 1'b1;
        end
        MC_DATA_EX: begin
          if (cur_st == ST_IS) begin
            nxt_st = ST_E; nxt_dirty = mdirty; hit = 1'b1;
          end else if (cur_st == ST_IM || cur_st == ST_SM) begin
            nxt_st = ST_M; nxt_dirty = 1'b1; hit = 1'b1; hit_st = 1'b1;
          end
        end
        MC_STALE: if (cur_st == ST_IS) begin
          nxt_st = ST_I; nxt_dirty = 1'b0; hit = 1'b1;
        end
        MC_INV: begin
          send = 1'b1;
          send_cls = OC_IACK;
          case (cur_st)
            ST_SM: nxt_st = ST_IM;
            ST_S, ST_E: begin
              nxt_st = ST_I; nxt_dirty = 1'b0; evict = 1'b1;
            end
            ST_M: begin
              nxt_st = ST_I; nxt_dirty = 1'b0; evict = 1'b1;
              send_cls = OC_IDATA; send_dirty = cur_dirty; send_data = 1'b1;
            end
            default: ;
          endcase
        end
        MC_FGETX, MC_UPGR: begin
          if (cur_st == ST_E) begin
            send = 1'b1; send_cls = OC_IACK;
            nxt_st = ST_I; nxt_dirty = 1'b0; evict = 1'b1;
          end else if (cur_st == ST_M) begin
            send = 1'b1; send_cls = OC_IDATA;
            send_dirty = cur_dirty; send_data = 1'b1;
            nxt_st = ST_I; nxt_dirty = 1'b0; evict = 1'b1;
          end
        end
        MC_FGETS, MC_FGETI: if (cur_st == ST_E || cur_st == ST_M) begin
          send = 1'b1; send_cls = OC_IDATA;
          send_dirty = cur_dirty; send_data = 1'b1;
          nxt_st = ST_S;
        end
        default: ;
      endcase
    end else if (ev_valid) begin
      case (cur_st)
        ST_NP, ST_I: begin
          nxt_dirty = 1'b0;
          if (op == OP_STORE) begin
            nxt_st = ST_IM; send = 1'b1; send_cls = OC_GETX;
          end else if (op == OP_REPL) begin
            nxt_st = ST_NP;
          end else begin
            nxt_st = ST_IS; send = 1'b1; send_cls = OC_GETS;
          end
        end
        ST_S: begin
          if (op == OP_STORE) begin
            nxt_st = ST_SM; send = 1'b1; send_cls = OC_UPGR;
          end else if (op == OP_REPL) begin
            nxt_st = ST_I; nxt_dirty = 1'b0; evict = 1'b1;
          end else begin
            hit = 1'b1;
          end
        end
        ST_E, ST_M: begin
          if (op == OP_STORE) begin
            nxt_st = ST_M; nxt_dirty = 1'b1; hit = 1'b1; hit_st = 1'b1;
          end else if (op == OP_REPL) begin
            send = 1'b1; send_cls = OC_PUTX;
            send_dirty = cur_dirty; send_data = cur_dirty;
            nxt_st = ST_I; nxt_dirty = 1'b0; evict = 1'b1;
          end else begin
            hit = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mesi_out_pipe.sv
module mesi_out_pipe #(
  parameter int DEPTH = 2,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data
);
  logic [DEPTH-1:0] v_q;
  logic [WIDTH-1:0] d_q [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (i == 0) begin
        v_q[i] <= rst ? 1'b0 : in_valid;
        d_q[i] <= in_data;
      end else begin
        v_q[i] <= rst ? 1'b0 : v_q[i-1];
        d_q[i] <= d_q[i-1];
      end
    end
  end

  assign out_valid = v_q[DEPTH-1];
  assign out_data  = d_q[DEPTH-1];

  generate
    for (genvar g = 1; g < DEPTH; g++) begin : g_chk
      // R11: each stage only fires one cycle after its predecessor
      a_r11_stage_carry: assert property (@(posedge clk) disable iff (rst)
        v_q[g] |-> $past(v_q[g-1]));
    end
  endgenerate
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int LINES      = 16,
  parameter int OUT_LAT    = 2,
  parameter bit SEND_EVICT = 1'b1,
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_valid,
  input  logic [1:0]    cpu_op,
  input  logic [LW-1:0] cpu_line,
  output logic          cpu_ready,
  input  logic          msg_valid,
  input  logic [3:0]    msg_class,
  input  logic [LW-1:0] msg_line,
  input  logic          msg_dirty,
  output logic          out_valid,
  output logic [2:0]    out_class,
  output logic [LW-1:0] out_line,
  output logic          out_dirty,
  output logic          out_has_data,
  output logic          hit_valid,
  output logic [LW-1:0] hit_line,
  output logic          hit_store,
  output logic          evict_valid,
  output logic [LW-1:0] evict_line
);
  localparam int PW = 5 + LW;

  line_st_t st_q    [LINES];
  logic     dirty_q [LINES];

  line_st_t st_cpu, st_msg, cur_st, nxt_st;
  logic     cur_dirty, nxt_dirty;
  logic     cpu_fire, msg_fire, ev_fire;
  logic [LW-1:0] sel_line;
  logic     x_send, x_sdirty, x_sdata, x_hit, x_hitst, x_evict;
  out_cls_t x_scls;
  logic [PW-1:0] pay_in, pay_out;

  assign st_cpu    = st_q[cpu_line];
  assign st_msg    = st_q[msg_line];
  assign msg_fire  = msg_valid && !rst;
  assign cpu_ready = !rst && !msg_valid && !is_wait(st_cpu);
  assign cpu_fire  = cpu_valid && cpu_ready;
  assign ev_fire   = msg_fire || cpu_fire;
  assign sel_line  = msg_fire ? msg_line : cpu_line;
  assign cur_st    = msg_fire ? st_msg : st_cpu;
  assign cur_dirty = dirty_q[sel_line];

  mesi_xfer u_xfer (
    .ev_valid  (ev_fire),
    .ev_msg    (msg_fire),
    .op        (cpu_op_t'(cpu_op)),
    .mcls      (msg_cls_t'(msg_class)),
    .mdirty    (msg_dirty),
    .cur_st    (cur_st),
    .cur_dirty (cur_dirty),
    .nxt_st    (nxt_st),
    .nxt_dirty (nxt_dirty),
    .send      (x_send),
    .send_cls  (x_scls),
    .send_dirty(x_sdirty),
    .send_data (x_sdata),
    .hit       (x_hit),
    .hit_st    (x_hitst),
    .evict     (x_evict)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]    <= ST_NP;
        dirty_q[i] <= 1'b0;
      end
    end else if (ev_fire) begin
      st_q[sel_line]    <= nxt_st;
      dirty_q[sel_line] <= nxt_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_valid   <= 1'b0;
      hit_store   <= 1'b0;
      hit_line    <= '0;
      evict_valid <= 1'b0;
      evict_line  <= '0;
    end else begin
      hit_valid   <= x_hit;
      hit_store   <= x_hitst;
      hit_line    <= sel_line;
      evict_valid <= x_evict && SEND_EVICT;
      evict_line  <= sel_line;
    end
  end

  assign pay_in = {x_scls, x_sdirty, x_sdata, sel_line};

  mesi_out_pipe #(.DEPTH(OUT_LAT), .WIDTH(PW)) u_pipe (
    .clk      (clk),
    .rst      (rst),
    .in_valid (x_send),
    .in_data  (pay_in),
    .out_valid(out_valid),
    .out_data (pay_out)
  );

  assign out_class    = pay_out[PW-1 -: 3];
  assign out_dirty    = pay_out[LW+1];
  assign out_has_data = pay_out[LW];
  assign out_line     = pay_out[LW-1:0];

  // R4: store to a shared line parks it in upgrade-wait
  a_r4_s_store_wait: assert property (@(posedge clk) disable iff (rst)
    cpu_fire && cpu_op == OP_STORE && st_cpu == ST_S
    |=> st_q[$past(cpu_line)] == ST_SM);

  // R4: store to an owned line completes at once and marks it dirty
  a_r4_owned_store: assert property (@(posedge clk) disable iff (rst)
    cpu_fire && cpu_op == OP_STORE && (st_cpu == ST_E || st_cpu == ST_M)
    |=> hit_valid && hit_store && dirty_q[$past(cpu_line)]);

  // R6: stale fill completes the load and leaves the line invalid
  a_r6_stale_fill: assert property (@(posedge clk) disable iff (rst)
    msg_fire && msg_class == MC_STALE && st_msg == ST_IS
    |=> hit_valid && !hit_store && st_q[$past(msg_line)] == ST_I);

  // R11: a completion notice always follows an accepted event
  a_r11_hit_origin: assert property (@(posedge clk) disable iff (rst)
    hit_valid |-> $past(ev_fire));
endmodule

// File: tb/mesi_line_ctrl_tb.sv
`timescale 1ns/1ps
module mesi_line_ctrl_tb_top;
  localparam int LINES = 8;
  localparam int LW = $clog2(LINES);
  localparam int NP = 0, I = 1, S = 2, E = 3, M = 4, IS = 5, IM = 6, SM = 7;

  logic clk = 1'b0;
  logic rst;
  logic cpu_valid, msg_valid, msg_dirty;
  logic [1:0] cpu_op;
  logic [3:0] msg_class;
  logic [LW-1:0] cpu_line, msg_line;
  logic cpu_ready, out_valid, out_dirty, out_has_data;
  logic [2:0] out_class;
  logic [LW-1:0] out_line, hit_line, evict_line;
  logic hit_valid, hit_store, evict_valid;

  always #2.5 clk = ~clk;

  mesi_line_ctrl #(.LINES(LINES)) dut_i (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_line(cpu_line), .cpu_ready(cpu_ready),
    .msg_valid(msg_valid), .msg_class(msg_class), .msg_line(msg_line), .msg_dirty(msg_dirty),
    .out_valid(out_valid), .out_class(out_class), .out_line(out_line),
    .out_dirty(out_dirty), .out_has_data(out_has_data),
    .hit_valid(hit_valid), .hit_line(hit_line), .hit_store(hit_store),
    .evict_valid(evict_valid), .evict_line(evict_line)
  );

  int total = 0, bad = 0;
  int mst [LINES];
  bit mdt [LINES];
  bit e_send, e_sdirty, e_sdata, e_hit, e_hst, e_ev;
  int e_cls;
  string e_tag;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit waiting(input int s);
    return s == IS || s == IM || s == SM;
  endfunction

  // expected behaviour from the requirements
  task automatic model(input bit m, input int code, input int ln, input bit md);
    int s = mst[ln];
    e_send = 0; e_sdirty = 0; e_sdata = 0; e_hit = 0; e_hst = 0; e_ev = 0; e_cls = 0;
    if (m) begin
      if (code <= 2) begin
        e_tag = "R6";
        if (s == IS) begin
          e_hit = 1;
          if (code == 0) begin mst[ln] = S; mdt[ln] = md; end
          else if (code == 1) begin mst[ln] = E; mdt[ln] = md; end
          else begin mst[ln] = I; mdt[ln] = 0; end
        end else if (code == 1 && (s == IM || s == SM)) begin
          e_hit = 1; e_hst = 1; mst[ln] = M; mdt[ln] = 1;
        end else e_tag = "R13";
      end else if (code == 3) begin
        e_tag = "R7"; e_send = 1; e_cls = 5;
        if (s == SM) mst[ln] = IM;
        else if (s == S || s == E) begin mst[ln] = I; mdt[ln] = 0; e_ev = 1; end
        else if (s == M) begin
          e_cls = 4; e_sdirty = mdt[ln]; e_sdata = 1; e_ev = 1; mst[ln] = I; mdt[ln] = 0;
        end
      end else if (code == 5 || code == 7) begin
        e_tag = "R8";
        if (s == E) begin e_send = 1; e_cls = 5; e_ev = 1; mst[ln] = I; mdt[ln] = 0; end
        else if (s == M) begin
          e_send = 1; e_cls = 4; e_sdirty = mdt[ln]; e_sdata = 1; e_ev = 1;
          mst[ln] = I; mdt[ln] = 0;
        end
      end else if (code == 4 || code == 6) begin
        e_tag = "R9";
        if (s == E || s == M) begin
          e_send = 1; e_cls = 4; e_sdirty = mdt[ln]; e_sdata = 1; mst[ln] = S;
        end
      end else e_tag = "R13";
    end else begin
      if (s == NP || s == I) begin
        e_tag = "R2"; mdt[ln] = 0;
        if (code == 2) begin e_send = 1; e_cls = 1; mst[ln] = IM; end
        else if (code == 3) mst[ln] = NP;
        else begin e_send = 1; e_cls = 0; mst[ln] = IS; end
      end else if (s == S) begin
        if (code == 2) begin e_tag = "R4"; e_send = 1; e_cls = 2; mst[ln] = SM; end
        else if (code == 3) begin e_tag = "R10"; e_ev = 1; mst[ln] = I; end
        else begin e_tag = "R5"; e_hit = 1; end
      end else begin
        if (code == 2) begin e_tag = "R4"; e_hit = 1; e_hst = 1; mst[ln] = M; mdt[ln] = 1; end
        else if (code == 3) begin
          e_tag = "R10"; e_send = 1; e_cls = 3; e_sdirty = mdt[ln]; e_sdata = mdt[ln];
          e_ev = 1; mst[ln] = I; mdt[ln] = 0;
        end else begin e_tag = "R5"; e_hit = 1; end
      end
    end
  endtask

  task automatic ev(input bit m, input int code, input int ln, input bit md, input bit both);
    bit acc;
    @(negedge clk);
    if (m) begin
      msg_valid = 1; msg_class = 4'(code); msg_line = LW'(ln); msg_dirty = md;
    end
    if (!m) begin cpu_valid = 1; cpu_op = 2'(code); cpu_line = LW'(ln); end
    if (both) begin cpu_valid = 1; cpu_op = 2'd0; cpu_line = LW'((ln + 1) % LINES); end
    #1;
    if (both) chk(cpu_ready == 0, "R12", "cpu_ready", int'(cpu_ready), 0);
    acc = 1;
    if (!m) begin
      acc = !waiting(mst[ln]);
      chk(cpu_ready == acc, "R3", "cpu_ready", int'(cpu_ready), int'(acc));
    end
    if (acc) model(m, code, ln, md);
    else begin
      e_send = 0; e_hit = 0; e_hst = 0; e_ev = 0; e_tag = "R3";
    end
    @(posedge clk);
    @(negedge clk);
    cpu_valid = 0; msg_valid = 0;
    chk(hit_valid == e_hit, e_tag, "hit_valid", int'(hit_valid), int'(e_hit));
    if (e_hit) begin
      chk(hit_store == e_hst, e_tag, "hit_store", int'(hit_store), int'(e_hst));
      chk(hit_line == LW'(ln), e_tag, "hit_line", int'(hit_line), ln);
    end
    chk(evict_valid == e_ev, e_tag, "evict_valid", int'(evict_valid), int'(e_ev));
    if (e_ev) chk(evict_line == LW'(ln), e_tag, "evict_line", int'(evict_line), ln);
    chk(out_valid == 0, "R11", "early out_valid", int'(out_valid), 0);
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == e_send, e_tag, "out_valid", int'(out_valid), int'(e_send));
    if (e_send) begin
      chk(out_class == 3'(e_cls), e_tag, "out_class", int'(out_class), e_cls);
      chk(out_line == LW'(ln), e_tag, "out_line", int'(out_line), ln);
      chk(out_dirty == e_sdirty, e_tag, "out_dirty", int'(out_dirty), int'(e_sdirty));
      chk(out_has_data == e_sdata, e_tag, "out_has_data", int'(out_has_data), int'(e_sdata));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R11 act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; cpu_valid = 0; msg_valid = 0; cpu_op = 0; msg_class = 0;
    cpu_line = 0; msg_line = 0; msg_dirty = 0;
    for (int i = 0; i < LINES; i++) begin mst[i] = NP; mdt[i] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(out_valid == 0 && hit_valid == 0 && evict_valid == 0, "R1", "valids",
        int'({out_valid, hit_valid, evict_valid}), 0);
    chk(cpu_ready == 1, "R1", "cpu_ready", int'(cpu_ready), 1);
    // line 0: shared, upgrade, race with invalidate, write-back
    ev(0, 0, 0, 0, 0);  ev(1, 0, 0, 0, 0);  ev(0, 0, 0, 0, 0);
    ev(0, 2, 0, 0, 0);  ev(0, 0, 0, 0, 0);  ev(0, 0, 1, 0, 0);
    ev(1, 3, 0, 0, 0);  ev(1, 1, 0, 0, 0);  ev(0, 3, 0, 0, 0);
    // line 1: invalidate while reading, stale fill, exclusive, forwarded read
    ev(1, 3, 1, 0, 0);  ev(1, 2, 1, 1, 0);  ev(0, 1, 1, 0, 0);
    ev(1, 1, 1, 0, 0);  ev(0, 2, 1, 0, 0);  ev(1, 4, 1, 0, 0);  ev(1, 3, 1, 0, 0);
    // line 2: store miss then incoming upgrade-class message
    ev(0, 2, 2, 0, 0);  ev(1, 1, 2, 0, 0);  ev(1, 7, 2, 0, 0);
    // line 3: forwarded GETX on clean exclusive, clean replacement
    ev(0, 0, 3, 0, 0);  ev(1, 1, 3, 0, 0);  ev(1, 5, 3, 0, 0);
    ev(0, 0, 3, 0, 0);  ev(1, 1, 3, 0, 0);  ev(0, 3, 3, 0, 0);
    // R13: write-back ack to an idle line changes nothing
    ev(1, 8, 4, 0, 0);  ev(0, 0, 4, 0, 0);
    // R12: message and processor event in the same cycle
    ev(1, 3, 6, 0, 1);  ev(0, 0, 7, 0, 0);
    // R10: shared replacement evicts silently
    ev(1, 0, 7, 0, 0);  ev(0, 3, 7, 0, 0);
    // random mix
    for (int k = 0; k < 1500; k++) begin
      int ln = int'($urandom % LINES);
      if ($urandom % 2) ev(0, int'($urandom % 4), ln, 0, 0);
      else ev(1, int'($urandom % 9), ln, 1'($urandom % 2), ($urandom % 8) == 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule